// File: doc/BRIEF.md
# Master Clock Source Switch Controller

This block picks the master clock from four sources (a 16 MHz internal RC, a 128 kHz internal RC, an external crystal and an external user-driven clock) and derives a CPU clock from it. Software requests a new source by writing a one-byte code into a target register. The switch finishes only when the target oscillator reports ready and both clocks are low at the same moment. Only then does the read-only status code change to the new source. A completion flag rises at the same time, and it can drive an interrupt that wakes the core from wait mode. Writes that carry an unknown code are dropped.

Two power-of-two dividers sit in the clock path. One is a prescaler on the 16 MHz internal RC, ahead of the mux. The other divides the master clock down to the CPU clock only, so the peripheral master clock keeps its rate. The oscillators are modelled by enable outputs and ready inputs. Source clock levels arrive as inputs sampled in the controller clock domain, and the mux is modelled behaviourally. The source that is running, and a source that a pending switch is waiting for, can never be powered down by software. A source is released only once the switch has moved away from it.

The write port has four byte addresses. Address 0 holds the target code. Address 1 holds the dividers. Address 2 holds the oscillator enables and the interrupt enable. Address 3 is the status code, which is read-only, so writes to it are dropped.

Top module: `mclk_switch`

## Requirements
- R1: After reset the active and target codes are E1h, the flag and interrupt are low, osc_en_o is 3'b001, and the master clock is the 16 MHz RC divided by 8. The CPU clock equals the master clock.
- R2: A write to address 0 of E1h selects the 16 MHz RC (index 0), D2h the 128 kHz RC (index 1) and B4h the external high-speed source (index 2). osc_en_o and osc_rdy_i use the same bit indices.
- R3: A write to address 0 of any other value changes neither the target code, the active code, the master clock nor the completion flag.
- R4: cur_code_o changes only when a switch completes. Writes to address 3 have no effect.
- R5: A switch cannot complete while osc_rdy_i of the target is low. The target's osc_en_o bit is forced high while the switch is pending.
- R6: The mux changes source only on a cycle in which the sampled levels of both the old and the new clock are low.
- R7: sw_done_o rises when a switch completes and clears on the next accepted write to address 0. irq_o is sw_done_o gated by bit 3 of address 2.
- R8: Bits [4:3] of address 1 (reset 3) divide the 16 MHz RC by 1, 2, 4 or 8, for the values 0 to 3.
- R9: Bits [2:0] of address 1 (reset 0) divide the CPU clock by 2^n relative to the master clock. The master clock period does not change.
- R10: Bits [2:0] of address 2 (reset 3'b001) enable the oscillators. The active source stays enabled even when its bit is 0. It is released once it is no longer the active source.
- R11: A write to address 0 while a switch is pending is ignored.
- R12: With the external source active, hse_bypass_i=0 routes the crystal input and hse_bypass_i=1 routes the user clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock; also samples source levels |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| hsi_clk_i | input | 1 | 16 MHz internal RC level |
| lsi_clk_i | input | 1 | 128 kHz internal RC level |
| hse_xtal_clk_i | input | 1 | External crystal oscillator level |
| hse_ext_clk_i | input | 1 | External user clock level |
| hse_bypass_i | input | 1 | 1 selects the user clock as external source |
| osc_rdy_i | input | 3 | Oscillator ready per source index |
| osc_en_o | output | 3 | Oscillator enable per source index |
| mclk_o | output | 1 | Master clock |
| cpu_clk_o | output | 1 | Divided CPU clock |
| cur_code_o | output | 8 | Active-source code (read-only status) |
| next_code_o | output | 8 | Target-source code |
| sw_done_o | output | 1 | Switch-complete flag |
| irq_o | output | 1 | Switch-complete interrupt |

## Verification
The bench holds the target oscillator not ready for many cycles. A design that switched early would show the new status code or the new clock period too soon. It writes unknown codes, writes to the status address and writes during a pending switch. A design that latched any of these would change the target code, the active code or the flag. It clears every software oscillator enable while a source is running. A design without the protection would drop the running source's enable, and a design that held sources too long would keep the old source's enable after the flag rises. Master and CPU clock periods are measured for a table of divider settings, which catches a divider that also slows the peripheral clock or indexes the wrong tap.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int NSRC = 3;
  localparam logic [7:0] CODE_HSI = 8'hE1;
  localparam logic [7:0] CODE_LSI = 8'hD2;
  localparam logic [7:0] CODE_HSE = 8'hB4;

  localparam logic [1:0] ADDR_NEXT = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_OSC  = 2'd2;

  function automatic logic code_valid(input logic [7:0] c);
    return (c == CODE_HSI) || (c == CODE_LSI) || (c == CODE_HSE);
  endfunction

  function automatic logic [NSRC-1:0] code2oh(input logic [7:0] c);
    logic [NSRC-1:0] oh;
    case (c)
      CODE_LSI: oh = 3'b010;
      CODE_HSE: oh = 3'b100;
      default:  oh = 3'b001;
    endcase
    return oh;
  endfunction

  function automatic logic [7:0] oh2code(input logic [NSRC-1:0] oh);
    logic [7:0] c;
    case (oh)
      3'b010:  c = CODE_LSI;
      3'b100:  c = CODE_HSE;
      default: c = CODE_HSI;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mclk_pow2_div.sv
module mclk_pow2_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             out_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic             in_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   tap;
  logic             rise;

  assign rise = in_i & ~in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      in_q <= in_i;
      if (rise) cnt_q <= cnt_q + 1'b1;
    end
  end

  // tap 0 is the undivided (registered) input, tap k is /2^k
  assign tap   = {cnt_q, in_q};
  assign out_o = tap[sel_i];

  p_div_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> $past(rise));
endmodule

// File: rtl/mclk_cfg_regs.sv
module mclk_cfg_regs
  import mclk_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int CPU_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [4:0]       wr_data_i,
  input  logic [NSRC-1:0]  sel_i,
  input  logic [NSRC-1:0]  tgt_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic [PRE_W-1:0] pre_div_o,
  output logic [CPU_W-1:0] cpu_div_o,
  output logic [NSRC-1:0]  osc_en_o,
  output logic             irq_o
);
  logic [NSRC-1:0] sw_en_q;
  logic            irq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_div_o <= '1;
      cpu_div_o <= '0;
      sw_en_q   <= 3'b001;
      irq_en_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_DIV) begin
        pre_div_o <= wr_data_i[4:3];
        cpu_div_o <= wr_data_i[2:0];
      end else if (wr_addr_i == ADDR_OSC) begin
        sw_en_q  <= wr_data_i[2:0];
        irq_en_q <= wr_data_i[3];
      end
    end
  end

  // running source and pending target are never powered down
  assign osc_en_o = sw_en_q | sel_i | (busy_i ? tgt_i : '0);
  assign irq_o    = done_i & irq_en_q;
endmodule

// File: rtl/mclk_switch_ctrl.sv
module mclk_switch_ctrl
  import mclk_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic [NSRC-1:0] rdy_i,
  input  logic [NSRC-1:0] lvl_i,
  output logic [NSRC-1:0] sel_o,
  output logic [NSRC-1:0] tgt_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [7:0]      cur_code_o,
  output logic [7:0]      next_code_o
);
  logic [7:0]      next_q;
  logic [NSRC-1:0] sel_q, tgt_q;
  logic            busy_q, done_q;
  logic            nxt_wr, accept, handover;

  assign nxt_wr   = wr_en_i && (wr_addr_i == ADDR_NEXT);
  assign accept   = nxt_wr && code_valid(wr_data_i) && !busy_q;
  assign handover = busy_q && |(tgt_q & rdy_i) && !(|(sel_q & lvl_i)) && !(|(tgt_q & lvl_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= CODE_HSI;
      sel_q  <= 3'b001;
      tgt_q  <= 3'b001;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      next_q <= wr_data_i;
      tgt_q  <= code2oh(wr_data_i);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (handover) begin
      sel_q  <= tgt_q;
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign sel_o       = sel_q;
  assign tgt_o       = tgt_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign cur_code_o  = oh2code(sel_q);
  assign next_code_o = next_q;

  p_invalid_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxt_wr && !code_valid(wr_data_i)) |=> ($stable(next_q) && $stable(sel_q)));
  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_q) == 1);
  p_switch_needs_rdy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> |(sel_q & $past(rdy_i)));
  p_handover_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (((($past(sel_q) | sel_q) & $past(lvl_i))) == '0));
  p_done_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q));
  p_done_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !done_q);
  p_busy_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxt_wr && busy_q) |=> $stable(next_q));
endmodule

// File: rtl/mclk_switch.sv
module mclk_switch
  import mclk_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int CPU_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       hsi_clk_i,
  input  logic       lsi_clk_i,
  input  logic       hse_xtal_clk_i,
  input  logic       hse_ext_clk_i,
  input  logic       hse_bypass_i,
  input  logic [2:0] osc_rdy_i,
  output logic [2:0] osc_en_o,
  output logic       mclk_o,
  output logic       cpu_clk_o,
  output logic [7:0] cur_code_o,
  output logic [7:0] next_code_o,
  output logic       sw_done_o,
  output logic       irq_o
);
  logic [PRE_W-1:0] pre_div;
  logic [CPU_W-1:0] cpu_div;
  logic [NSRC-1:0]  sel, tgt, lvl;
  logic             busy, hsi_lvl, lsi_q, hse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsi_q <= 1'b0;
      hse_q <= 1'b0;
    end else begin
      lsi_q <= lsi_clk_i;
      hse_q <= hse_bypass_i ? hse_ext_clk_i : hse_xtal_clk_i;
    end
  end

  mclk_pow2_div #(.SEL_W(PRE_W)) i_pre_div (
    .clk_i, .rst_ni, .in_i(hsi_clk_i), .sel_i(pre_div), .out_o(hsi_lvl)
  );

  assign lvl = {hse_q, lsi_q, hsi_lvl};

  mclk_switch_ctrl i_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rdy_i(osc_rdy_i), .lvl_i(lvl), .sel_o(sel), .tgt_o(tgt),
    .busy_o(busy), .done_o(sw_done_o), .cur_code_o, .next_code_o
  );

  mclk_cfg_regs #(.PRE_W(PRE_W), .CPU_W(CPU_W)) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i(wr_data_i[4:0]),
    .sel_i(sel), .tgt_i(tgt), .busy_i(busy), .done_i(sw_done_o),
    .pre_div_o(pre_div), .cpu_div_o(cpu_div), .osc_en_o, .irq_o
  );

  // behavioural glitch-free mux: select only moves while both levels are low
  assign mclk_o = |(sel & lvl);

  mclk_pow2_div #(.SEL_W(CPU_W)) i_cpu_div (
    .clk_i, .rst_ni, .in_i(mclk_o), .sel_i(cpu_div), .out_o(cpu_clk_o)
  );

  p_active_enabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel & ~osc_en_o) == '0);
endmodule

// File: tb/test_mclk_switch.sv
module test_mclk_switch;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       hsi = 1'b0, lsi = 1'b0, xtal = 1'b0, ext = 1'b0, bypass = 1'b0;
  logic [2:0] rdy = 3'b001;
  logic [2:0] osc_en;
  logic       mclk, cpu_clk, done, irq;
  logic [7:0] cur_code, next_code;
  int checks = 0, errors = 0, cyc = 0;

  mclk_switch i_mclk_switch (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hsi_clk_i(hsi), .lsi_clk_i(lsi), .hse_xtal_clk_i(xtal), .hse_ext_clk_i(ext),
    .hse_bypass_i(bypass), .osc_rdy_i(rdy), .osc_en_o(osc_en), .mclk_o(mclk),
    .cpu_clk_o(cpu_clk), .cur_code_o(cur_code), .next_code_o(next_code),
    .sw_done_o(done), .irq_o(irq)
  );

  always #5 clk = ~clk;

  // source levels: periods of 4, 40, 6 and 10 controller cycles
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc % 2 == 0)  hsi = ~hsi;
      if (cyc % 20 == 0) lsi = ~lsi;
      if (cyc % 3 == 0)  xtal = ~xtal;
      if (cyc % 5 == 0)  ext = ~ext;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic period(input bit use_cpu, output int p);
    logic prev, cur;
    int n;
    for (int k = 0; k < 2; k++) begin
      n = 0;
      prev = use_cpu ? cpu_clk : mclk;
      for (int g = 0; g < 20000; g++) begin
        @(negedge clk);
        n++;
        cur = use_cpu ? cpu_clk : mclk;
        if (!prev && cur) break;
        prev = cur;
      end
    end
    p = n;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 500; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  // {pre_div, cpu_div, mclk period, cpu period}
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{3, 0, 32, 32}, '{0, 0, 4, 4}, '{1, 2, 8, 32},
    '{2, 1, 16, 32}, '{0, 7, 4, 512}, '{3, 3, 32, 256}
  };

  initial begin
    int p;
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur", cur_code, 8'hE1);
    chk("R1 next", next_code, 8'hE1);
    chk("R1 done", done, 0);
    chk("R1 irq", irq, 0);
    chk("R1 osc_en", osc_en, 3'b001);
    period(0, p); chk("R1 mclk hsi/8", p, 32);
    period(1, p); chk("R1 cpu", p, 32);

    for (int v = 0; v < NV; v++) begin
      wr(2'd1, 8'((VEC[v][0] << 3) | VEC[v][1]));
      period(0, p); chk("R8 mclk period", p, VEC[v][2]);
      period(1, p); chk("R9 cpu period", p, VEC[v][3]);
    end
    wr(2'd1, 8'h18);

    // switch to 128 kHz RC with ready held low
    wr(2'd0, 8'hD2);
    chk("R5 target forced on", osc_en, 3'b011);
    repeat (50) @(negedge clk);
    chk("R5 cur while unready", cur_code, 8'hE1);
    chk("R5 done while unready", done, 0);
    wr(2'd0, 8'hE1);
    chk("R11 busy write ignored", next_code, 8'hD2);
    rdy[1] = 1'b1;
    wait_done();
    chk("R2 cur lsi", cur_code, 8'hD2);
    chk("R7 done set", done, 1);
    period(0, p); chk("R2 mclk lsi", p, 40);

    wr(2'd0, 8'h55);
    chk("R3 next kept", next_code, 8'hD2);
    chk("R3 cur kept", cur_code, 8'hD2);
    chk("R3 flag kept", done, 1);
    period(0, p); chk("R3 mclk kept", p, 40);
    wr(2'd3, 8'hE1);
    chk("R4 status write ignored", cur_code, 8'hD2);

    wr(2'd2, 8'h00);
    chk("R10 active kept, old released", osc_en, 3'b010);

    // switch to external source, ready low first
    wr(2'd0, 8'hB4);
    chk("R7 flag cleared", done, 0);
    chk("R10 old kept until done", osc_en, 3'b110);
    repeat (20) @(negedge clk);
    chk("R4 cur before done", cur_code, 8'hD2);
    rdy[2] = 1'b1;
    wait_done();
    chk("R2 cur hse", cur_code, 8'hB4);
    chk("R10 lsi released", osc_en, 3'b100);
    chk("R7 irq masked", irq, 0);
    period(0, p); chk("R12 crystal", p, 6);
    wr(2'd2, 8'h08);
    chk("R7 irq", irq, 1);
    bypass = 1'b1;
    period(0, p); chk("R12 user clock", p, 10);

    wr(2'd0, 8'hE1);
    chk("R7 irq clears", irq, 0);
    wait_done();
    chk("R2 cur hsi", cur_code, 8'hE1);
    chk("R10 hsi only", osc_en, 3'b001);
    period(0, p); chk("R6 mclk hsi/8", p, 32);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule